// File: doc/BRIEF.md
# Programmable Skew Clock Bank Generator

This block builds eight clock outputs, arranged as four banks of two, from one base clock. The block runs on a fast clock whose period is one time unit (tU). A phase count divides each base period into N units, and N comes from a three-level range select. Each bank reads two three-level select pins. Their nine combinations pick one of four things for the bank: a whole-tU lead or lag against the base clock, a divide-by-2, a divide-by-4, or an inverted copy of the base clock.

A polarity input picks which edge of the base clock is the reference. That edge is where the divided outputs change. The block is meant for static or reset-time configuration. Select pins are normally strapped. A select pin that is left floating reads as the middle level, so a bank whose pins are both floating gives zero skew.

Top module: `skew_clock_banks`

## Requirements
- R1: After reset is released, count k advances by one per clock. A zero-skew output (code MM) is high for counts 0 to N/2-1 and low for counts N/2 to N-1 of every period. While reset is held, the count stays at 0 and the divider state stays at 0.
- R2: `range_sel` sets N. 2'b00 gives N=44, 2'b10 gives N=16, and 2'b01 or 2'b11 gives N=26.
- R3: Each three-level pin is a 2-bit code: 2'b00 is LOW, 2'b01 is MID and 2'b10 is HIGH. 2'b11 also reads as MID, which is the level a floating pin takes. Bank b (0-based) takes its first code letter from `bank_sel[4b+3:4b+2]` and its second letter from `bank_sel[4b+1:4b]`.
- R4: Banks 0 and 1 delay the zero-skew waveform by s counts, modulo N. The codes LL, LM, LH, ML, MM, MH, HL, HM and HH give s = -4, -3, -2, -1, 0, +1, +2, +3 and +4. A negative s moves the edges earlier.
- R5: Banks 2 and 3 use twice those steps. LM gives -6, LH gives -4, ML gives -2, MM gives 0, MH gives +2, HL gives +4 and HM gives +6.
- R6: Code LL on bank 2 or bank 3 gives divide-by-2. The output starts low at reset and toggles each time the count reaches the reference point.
- R7: Code HH on bank 2 gives divide-by-4. It starts low, and every rising edge coincides with a rising edge of a divide-by-2 output.
- R8: Code HH on bank 3 gives the inverted zero-skew waveform. It is low for counts 0 to N/2-1 and high for the rest of the period.
- R9: With `edge_pos` high, the reference point is count 0. With `edge_pos` low, it is count N/2, and the divided outputs change there.
- R10: The two outputs of a bank are always equal. Bank b drives `clk_out[2b]` and `clk_out[2b+1]`.
- R11: The count never reaches N while the range is held, so each zero-skew period lasts exactly N clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one tU per period |
| rst_n | input | 1 | Synchronous reset, active low |
| range_sel | input | 2 | Three-level range code that sets units per base period |
| edge_pos | input | 1 | 1: reference on base rising edge; 0: on falling edge |
| bank_sel | input | 16 | Two three-level codes per bank, four bits per bank |
| clk_out | output | 8 | Bank outputs, two adjacent bits per bank |

## Verification
Two functions can act in the same cycle. A divide-by-2 bank and the divide-by-4 bank both change at the reference count, and the divide-by-4 rising edge must land on the very count where the divide-by-2 output rises. The bench provokes this by setting bank 2 to HH and bank 3 to LL under both polarities. At every count where bank 2 rises, it checks that bank 3 rises in that same count. The full sweep of codes, ranges and polarities also predicts both outputs count by count, so a divider step that is one count off, or that happens at the wrong reference point, shows up as a mismatch.

// File: rtl/skew_bank_pkg.sv
// Shared types and decode helpers for the skew clock bank generator.
// Assumes three-level pins are encoded as 2-bit codes, with 2'b11 read as MID.
package skew_bank_pkg;

    typedef enum logic [1:0] {
        MODE_NOM  = 2'd0,
        MODE_DIV2 = 2'd1,
        MODE_DIV4 = 2'd2,
        MODE_INV  = 2'd3
    } bank_mode_e;

    typedef struct packed {
        bank_mode_e       mode;
        logic signed [4:0] skew;
    } bank_cfg_t;

    // Map a 2-bit pin code to level index 0 (LOW), 1 (MID), 2 (HIGH).
    function automatic logic [1:0] lvl_index(input logic [1:0] code);
        case (code)
            2'b00:   return 2'd0;
            2'b10:   return 2'd2;
            default: return 2'd1;
        endcase
    endfunction

    // Turn a pin pair into a mode and a signed skew in tU.
    function automatic bank_cfg_t decode_cfg(input logic [1:0] hi, input logic [1:0] lo,
                                             input logic wide, input logic inv_top);
        int        idx;
        int        step;
        bank_cfg_t c;
        idx    = 3 * int'(lvl_index(hi)) + int'(lvl_index(lo));
        step   = idx - 4;
        c.mode = MODE_NOM;
        c.skew = wide ? 5'(2 * step) : 5'(step);
        if (wide && idx == 0) c.mode = MODE_DIV2;
        if (wide && idx == 8) c.mode = inv_top ? MODE_INV : MODE_DIV4;
        return c;
    endfunction

endpackage

// File: rtl/phase_counter.sv
// Phase counter spanning one base period of n_cnt time units.
// Assumes n_cnt >= 2. A count at or beyond the last unit wraps to zero,
// so a smaller range taking effect mid-count recovers in one cycle.
module phase_counter #(
    parameter int PH_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] n_cnt,
    output logic [PH_W-1:0] phase,
    output logic [PH_W-1:0] phase_nxt
);

    // Next count: wrap after the last unit of the period.
    always_comb begin
        if (phase >= PH_W'(n_cnt - 1'b1)) phase_nxt = '0;
        else                               phase_nxt = phase + 1'b1;
    end

    // Count register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase_nxt;
    end

    // R11: with a steady range the count stays inside the period
    a_r11_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(n_cnt) |-> (phase < n_cnt));

    // R1: away from wrap, the count advances by exactly one
    a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != '0) |-> (phase == PH_W'($past(phase) + 1'b1)));

endmodule

// File: rtl/edge_divider.sv
// Shared divide-by-2 / divide-by-4 state stepped at the reference count.
// Assumes it is cleared by the same reset as the phase counter, so all
// divided outputs start aligned. The divide-by-4 encoding makes its rising
// edge land on a divide-by-2 rising edge.
module edge_divider #(
    parameter int PH_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase,
    input  logic [PH_W-1:0] phase_nxt,
    input  logic [PH_W-1:0] ref_pt,
    output logic            div2,
    output logic            div4
);

    logic [1:0] step_q;

    // Advance the two-bit step each time the count enters the reference point.
    always_ff @(posedge clk) begin
        if (!rst_n)                  step_q <= 2'd0;
        else if (phase_nxt == ref_pt) step_q <= step_q + 2'd1;
    end

    // Output decode: div2 on bit 0, div4 high for steps 1 and 2.
    always_comb begin
        div2 = step_q[0];
        div4 = step_q[1] ^ step_q[0];
    end

    // R9: divider state only changes when the count sits on the reference point
    a_r9_div_at_ref: assert property (@(posedge clk) disable iff (!rst_n)
        ((step_q != $past(step_q)) && $stable(ref_pt)) |-> (phase == ref_pt));

    // R7: every divide-by-4 rise coincides with a divide-by-2 rise
    a_r7_div4_with_div2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div4) |-> $rose(div2));

endmodule

// File: rtl/skew_bank.sv
// One output bank: decodes its pin pair and drives both outputs identically.
// WIDE selects the doubled-step table with divide modes at the corner codes.
// INV_TOP makes the top corner code an inverted clock instead of divide-by-4.
module skew_bank
    import skew_bank_pkg::*;
#(
    parameter int PH_W    = 6,
    parameter bit WIDE    = 1'b0,
    parameter bit INV_TOP = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      sel_hi,
    input  logic [1:0]      sel_lo,
    input  logic [PH_W-1:0] phase,
    input  logic [PH_W-1:0] n_cnt,
    input  logic            div2,
    input  logic            div4,
    output logic [1:0]      pair_out
);

    localparam int SW = PH_W + 2;

    bank_cfg_t            cfg;
    logic signed [SW-1:0] n_s;
    logic signed [SW-1:0] half_s;
    logic signed [SW-1:0] diff;
    logic signed [SW-1:0] wrapped;
    logic                 nom;
    logic                 inv;
    logic                 sel_bit;

    // Decode the pin pair into mode and skew.
    always_comb cfg = decode_cfg(sel_hi, sel_lo, WIDE, INV_TOP);

    // Shift the count by the skew and fold it back into one period.
    always_comb begin
        n_s    = signed'({2'b00, n_cnt});
        half_s = signed'({3'b000, n_cnt[PH_W-1:1]});
        diff   = signed'({2'b00, phase}) - SW'(cfg.skew);
        if (diff < 0)         wrapped = diff + n_s;
        else if (diff >= n_s) wrapped = diff - n_s;
        else                  wrapped = diff;
        nom = (wrapped < half_s);
        inv = ({2'b00, phase} >= {3'b000, n_cnt[PH_W-1:1]});
    end

    // Pick the bank waveform by mode and copy it to both outputs.
    always_comb begin
        case (cfg.mode)
            MODE_DIV2: sel_bit = div2;
            MODE_DIV4: sel_bit = div4;
            MODE_INV:  sel_bit = inv;
            default:   sel_bit = nom;
        endcase
        pair_out = {2{sel_bit}};
    end

    // R4/R5: a skewed output only rises at the count equal to its skew modulo N
    a_r4_skew_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.mode == MODE_NOM) && $stable(sel_hi) && $stable(sel_lo)
         && $stable(n_cnt) && $rose(pair_out[0])) |-> (wrapped == 0));

endmodule

// File: rtl/skew_clock_banks.sv
// Top: four banks of two skew-programmable clocks driven from one phase count.
// Assumes range, polarity and bank selects are static or changed under reset.
// One clock period is one time unit; N units form a base period.
module skew_clock_banks
    import skew_bank_pkg::*;
#(
    parameter int N_LOW  = 44,
    parameter int N_MID  = 26,
    parameter int N_HIGH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  range_sel,
    input  logic        edge_pos,
    input  logic [15:0] bank_sel,
    output logic [7:0]  clk_out
);

    localparam int NUM_BANKS = 4;
    localparam int N_MAX1    = (N_LOW > N_MID) ? N_LOW : N_MID;
    localparam int N_MAX     = (N_MAX1 > N_HIGH) ? N_MAX1 : N_HIGH;
    localparam int PH_W      = $clog2(N_MAX + 1);

    logic [PH_W-1:0] n_cnt;
    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] phase_nxt;
    logic [PH_W-1:0] ref_pt;
    logic            div2;
    logic            div4;

    // Range decode: units per base period.
    always_comb begin
        case (lvl_index(range_sel))
            2'd0:    n_cnt = PH_W'(N_LOW);
            2'd2:    n_cnt = PH_W'(N_HIGH);
            default: n_cnt = PH_W'(N_MID);
        endcase
    end

    // Reference point: count 0 for the rising edge, mid-period for the falling edge.
    always_comb ref_pt = edge_pos ? '0 : (n_cnt >> 1);

    phase_counter #(.PH_W(PH_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .n_cnt     (n_cnt),
        .phase     (phase),
        .phase_nxt (phase_nxt)
    );

    edge_divider #(.PH_W(PH_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .phase_nxt (phase_nxt),
        .ref_pt    (ref_pt),
        .div2      (div2),
        .div4      (div4)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        skew_bank #(
            .PH_W    (PH_W),
            .WIDE    (b >= 2),
            .INV_TOP (b == 3)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_hi   (bank_sel[4*b+3 -: 2]),
            .sel_lo   (bank_sel[4*b+1 -: 2]),
            .phase    (phase),
            .n_cnt    (n_cnt),
            .div2     (div2),
            .div4     (div4),
            .pair_out (clk_out[2*b+1 -: 2])
        );
    end

    // R10: both outputs of every bank agree
    a_r10_pair_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out[0] == clk_out[1]) && (clk_out[2] == clk_out[3]) &&
        (clk_out[4] == clk_out[5]) && (clk_out[6] == clk_out[7]));

endmodule

// File: tb/skew_clock_banks_bench.sv
// Directed bench for the skew clock bank generator: one task per scenario.
module skew_clock_banks_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  range_sel = 2'b01;
    logic        edge_pos = 1'b1;
    logic [15:0] bank_sel = 16'h5555;
    logic [7:0]  clk_out;

    int checks = 0;
    int fails  = 0;

    always #5ns clk = ~clk;

    skew_clock_banks u_skew_clock_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .range_sel (range_sel),
        .edge_pos  (edge_pos),
        .bank_sel  (bank_sel),
        .clk_out   (clk_out)
    );

    // Level index 0/1/2 to pin code (R3).
    function automatic logic [1:0] enc(input int lvl);
        return (lvl == 0) ? 2'b00 : (lvl == 2) ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [15:0] sel_all(input int idx);
        logic [3:0] nib;
        nib = {enc(idx / 3), enc(idx % 3)};
        return {nib, nib, nib, nib};
    endfunction

    function automatic int n_of(input logic [1:0] r);
        return (r == 2'b00) ? 44 : (r == 2'b10) ? 16 : 26;
    endfunction

    // Expected bank output at count k after release, from the requirements.
    function automatic logic exp_out(input int bank, input int idx, input int n,
                                     input logic pos, input int k);
        int p, half, q, s, sh;
        bit wide;
        p    = k % n;
        half = n / 2;
        wide = (bank >= 2);
        q    = pos ? (k / n) : ((k + half) / n);
        if (wide && idx == 0) return logic'(q % 2);
        if (wide && idx == 8 && bank == 2) return logic'(((q >> 1) % 2) ^ (q % 2));
        if (wide && idx == 8 && bank == 3) return (p >= half);
        s  = (idx - 4) * (wide ? 2 : 1);
        sh = (((p - s) % n) + n) % n;
        return (sh < half);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Apply a setup under reset and release it at a falling edge.
    task automatic start(input logic [1:0] r, input logic pos, input logic [15:0] sel);
        @(negedge clk);
        rst_n     = 1'b0;
        range_sel = r;
        edge_pos  = pos;
        bank_sel  = sel;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // Run one setup, comparing every count against the model; one check per bank.
    task automatic run_model(input string req, input logic [1:0] r, input logic pos,
                             input logic [15:0] sel, input int idx);
        int n;
        logic [7:0] bad_act [4];
        logic [7:0] bad_exp [4];
        bit         bad [4];
        n = n_of(r);
        for (int b = 0; b < 4; b++) bad[b] = 1'b0;
        start(r, pos, sel);
        for (int k = 0; k < 4 * n + 3; k++) begin
            if (k > 0) begin
                @(negedge clk);
                #1;
            end
            for (int b = 0; b < 4; b++) begin
                logic e;
                e = exp_out(b, idx, n, pos, k);
                if (!bad[b] && (clk_out[2*b+1 -: 2] !== {e, e})) begin
                    bad[b]     = 1'b1;
                    bad_act[b] = {6'b0, clk_out[2*b+1 -: 2]};
                    bad_exp[b] = {6'b0, e, e};
                    $display("  bank %0d idx %0d range %b pos %b count %0d", b, idx, r, pos, k);
                end
            end
        end
        for (int b = 0; b < 4; b++)
            check(req, bad[b] ? bad_act[b] : 8'h00, bad[b] ? bad_exp[b] : 8'h00);
    endtask

    // R1/R8: outputs held at the count-0 state during reset.
    task automatic t_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        bank_sel = 16'h5555;
        repeat (2) @(negedge clk);
        #1;
        check("R1 reset all MM", clk_out, 8'hFF);
        bank_sel = 16'hA555;   // bank 3 HH: inverted, low at count 0 (R8)
        #1;
        check("R8 reset inverted bank", clk_out, 8'h3F);
    endtask

    // R1 R2 R4 R5 R6 R8 R9 R10 R11: all nine codes, all ranges, one polarity.
    task automatic t_sweep(input logic pos);
        logic [1:0] ranges [3] = '{2'b00, 2'b01, 2'b10};
        for (int ri = 0; ri < 3; ri++)
            for (int idx = 0; idx < 9; idx++)
                run_model(pos ? "R4 R5 R6 R8 R2 sweep rising ref"
                              : "R9 R6 R5 R2 sweep falling ref",
                          ranges[ri], pos, sel_all(idx), idx);
    endtask

    // R3: code 11 on any pin and on the range select behaves as MID.
    task automatic t_undriven();
        int codes [5] = '{1, 3, 4, 5, 7};
        for (int c = 0; c < 5; c++) begin
            logic [15:0] s;
            s = sel_all(codes[c]);
            for (int i = 0; i < 8; i++)
                if (s[2*i +: 2] == 2'b01) s[2*i +: 2] = 2'b11;
            run_model("R3 floating pin as MID", 2'b11, 1'b1, s, codes[c]);
        end
    endtask

    // R7: bank 2 divide-by-4 rises in the same count as bank 3 divide-by-2.
    task automatic t_coincide(input logic pos);
        int   rises;
        int   miss;
        logic prev2;
        logic prev3;
        rises = 0;
        miss  = 0;
        start(2'b10, pos, 16'h0A55);   // bank 3 LL, bank 2 HH
        prev2 = clk_out[4];
        prev3 = clk_out[6];
        for (int k = 1; k < 100; k++) begin
            @(negedge clk);
            #1;
            if (!prev2 && clk_out[4]) begin
                rises++;
                if (!(!prev3 && clk_out[6])) miss++;
            end
            prev2 = clk_out[4];
            prev3 = clk_out[6];
        end
        check("R7 div4 rise count", 8'(rises > 0), 8'd1);
        check("R7 div4 rise with div2", 8'(miss), 8'd0);
    endtask

    initial begin
        #2ms;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_sweep(1'b1);
        t_sweep(1'b0);
        t_undriven();
        t_coincide(1'b1);
        t_coincide(1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule